// File: doc/BRIEF.md
# Hart-Side Debug Handshake Memory

This block is the small memory window that a hart fetches from and stores to while it sits in debug mode. The hart reaches it through a 32-bit, word-addressed slave port. Readable regions hold a fixed branch word, the two instruction words of the current abstract command, the program buffer, the shared data words, a packed array of per-hart flag bytes and a small ROM image. Four write-only mailbox words let the hart report that it has halted, that it has picked up a command, that it is resuming, or that an exception occurred. Every request carries the ID of the hart that issued it.

The host-facing register logic sits outside this block. It drives a few plain inputs: the selected hart, pulses that launch a command or request a resume or clear the error field, write ports for the data words and the program buffer, and the two abstract-command words. The block returns the busy bit, the error field and the per-hart halted and resume-acknowledge vectors. The hart and the host never share a dedicated handshake wire. They coordinate only through the go and resume flag bits and the mailbox writes. When both sides touch the same state bit in one cycle, the hart-side event wins.

Top module: `dbgmem_window`

## Requirements
- R1: After reset all flags, halted and acknowledge bits, busy, the error field, the data words and the program buffer are zero, and no response is pending.
- R2: Every request gets exactly one response on the next cycle. A read of word address 0x040 returns 0x2000006F, a jump with rd = x0 whose offset (+0x200 bytes) reaches the abstract-command area at word 0x0C0.
- R3: A write to word 0x041 sets the halted bit of the writing hart. It clears busy only when that hart is the selected hart and its go flag was clear before the write.
- R4: A write to word 0x042 clears the go flag of the selected hart, whichever hart writes it.
- R5: A write to word 0x043 clears the writing hart's halted bit, sets its resume-acknowledge bit and clears its resume flag.
- R6: A write to word 0x044 sets the error field to 3 only if it is zero at that moment. Otherwise the field keeps its value.
- R7: Host go sets the selected hart's go flag and busy. Host resume sets the selected hart's resume flag and clears its acknowledge bit. Host error-clear zeroes the error field. When a hart event and a host update touch the same bit in one cycle, the hart event wins.
- R8: Word 0x100 packs one flag byte per hart. Hart h uses bits 8h+7..8h, with bit 0 = go and bit 1 = resume, and the other bits read zero.
- R9: The data words at 0x0D0 upward can be read and written by the hart and written by the host. When both write the same word in one cycle, the hart's value is kept. host_data_rdata shows the word chosen by host_data_idx.
- R10: Words 0x0C0 and 0x0C1 return abs_insn0 and abs_insn1. Words 0x0C2 upward return the program buffer, which the host writes and the hart can only read.
- R11: ROM words at 0x200 upward return ROM_SEED OR'd with the word index (default 0xD0B00000 + i).
- R12: An error response (rsp_err = 1, rsp_rdata = 0) is returned for an unmapped address, for a write to any read-only word and for a read of any mailbox. Such a request changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Hart request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 32 | Write data |
| req_hart | input | 2 | ID of the requesting hart |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_rdata | output | 32 | Read data (zero for writes and errors) |
| rsp_err | output | 1 | Error response |
| host_sel | input | 2 | Hart selected by the host |
| host_go | input | 1 | Launch a command on the selected hart |
| host_resume | input | 1 | Request a resume of the selected hart |
| host_err_clr | input | 1 | Clear the error field |
| host_data_we | input | 1 | Host write to a data word |
| host_data_idx | input | 1 | Data word index for host access |
| host_data_wdata | input | 32 | Host data write value |
| host_data_rdata | output | 32 | Data word at host_data_idx |
| host_pb_we | input | 1 | Host write to the program buffer |
| host_pb_idx | input | 2 | Program buffer index |
| host_pb_wdata | input | 32 | Program buffer write value |
| abs_insn0 | input | 32 | First abstract-command word |
| abs_insn1 | input | 32 | Second abstract-command word |
| busy | output | 1 | Abstract command in flight |
| err_code | output | 3 | Command error field |
| halted | output | 4 | Per-hart halted bits |
| resume_ack | output | 4 | Per-hart resume-acknowledge bits |

## Verification
Go and resume flags live only inside the block, so a wrong flag stays hidden until the hart reads the flag word or a later mailbox write depends on it. A wrong go bit shows up first as busy failing to clear after a halt notification. The bench therefore reads the flag word right after each host or mailbox update. Halted, acknowledge, busy and error are visible at the ports, and any fault in them shows one cycle after the write that caused it. The bench's model compares all of these every cycle, including cycles where both sides update the same bit at once.

// File: rtl/dbgmem_pkg.sv
package dbgmem_pkg;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_JUMP,
        RG_MB_HALT,
        RG_MB_GOING,
        RG_MB_RESUME,
        RG_MB_EXC,
        RG_ABS,
        RG_PROG,
        RG_DATA,
        RG_FLAGS,
        RG_ROM
    } region_e;

    localparam logic [2:0] ERR_EXC     = 3'd3;
    localparam int         ABS_WORDS   = 2;
    localparam int         FLAG_GO_B   = 0;
    localparam int         FLAG_RES_B  = 1;

    // jal x0, off : imm[20|10:1|11|19:12] rd opcode
    function automatic logic [31:0] jal_x0(input int off);
        logic [20:0] imm;
        imm = off[20:0];
        return {imm[20], imm[10:1], imm[11], imm[19:12], 5'd0, 7'b1101111};
    endfunction

endpackage

// File: rtl/dbgmem_decode.sv
module dbgmem_decode
    import dbgmem_pkg::*;
#(
    parameter int AW         = 10,
    parameter int JUMP_WADDR = 64,
    parameter int ABS_WADDR  = 192,
    parameter int PB_WORDS   = 4,
    parameter int DATA_WADDR = 208,
    parameter int DATA_WORDS = 2,
    parameter int FLAG_WADDR = 256,
    parameter int FLAG_WORDS = 1,
    parameter int ROM_WADDR  = 512,
    parameter int ROM_WORDS  = 8
) (
    input  logic [AW-1:0] addr,
    input  logic          write,
    output region_e       region,
    output logic [AW-1:0] offset,
    output logic          legal
);
    localparam int PB_WADDR = ABS_WADDR + ABS_WORDS;

    int a;

    always_comb begin
        a      = int'(addr);
        region = RG_NONE;
        offset = '0;
        if (a == JUMP_WADDR) begin
            region = RG_JUMP;
        end else if (a == JUMP_WADDR + 1) begin
            region = RG_MB_HALT;
        end else if (a == JUMP_WADDR + 2) begin
            region = RG_MB_GOING;
        end else if (a == JUMP_WADDR + 3) begin
            region = RG_MB_RESUME;
        end else if (a == JUMP_WADDR + 4) begin
            region = RG_MB_EXC;
        end else if (a >= ABS_WADDR && a < PB_WADDR) begin
            region = RG_ABS;
            offset = AW'(a - ABS_WADDR);
        end else if (a >= PB_WADDR && a < PB_WADDR + PB_WORDS) begin
            region = RG_PROG;
            offset = AW'(a - PB_WADDR);
        end else if (a >= DATA_WADDR && a < DATA_WADDR + DATA_WORDS) begin
            region = RG_DATA;
            offset = AW'(a - DATA_WADDR);
        end else if (a >= FLAG_WADDR && a < FLAG_WADDR + FLAG_WORDS) begin
            region = RG_FLAGS;
            offset = AW'(a - FLAG_WADDR);
        end else if (a >= ROM_WADDR && a < ROM_WADDR + ROM_WORDS) begin
            region = RG_ROM;
            offset = AW'(a - ROM_WADDR);
        end
    end

    always_comb begin
        if (write) begin
            legal = (region == RG_MB_HALT) || (region == RG_MB_GOING) ||
                    (region == RG_MB_RESUME) || (region == RG_MB_EXC) ||
                    (region == RG_DATA);
        end else begin
            legal = (region == RG_JUMP) || (region == RG_ABS) ||
                    (region == RG_PROG) || (region == RG_DATA) ||
                    (region == RG_FLAGS) || (region == RG_ROM);
        end
    end

endmodule

// File: rtl/dbgmem_flags.sv
module dbgmem_flags
    import dbgmem_pkg::*;
#(
    parameter int NHARTS = 4,
    localparam int HW    = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_halt,
    input  logic              ev_going,
    input  logic              ev_resume,
    input  logic              ev_exc,
    input  logic [HW-1:0]     ev_id,
    input  logic [HW-1:0]     sel,
    input  logic              host_go,
    input  logic              host_resume,
    input  logic              host_err_clr,
    output logic [NHARTS-1:0] go_o,
    output logic [NHARTS-1:0] res_o,
    output logic [NHARTS-1:0] halted_o,
    output logic [NHARTS-1:0] ack_o,
    output logic              busy_o,
    output logic [2:0]        err_o
);
    typedef struct packed {
        logic [NHARTS-1:0] go;
        logic [NHARTS-1:0] res;
        logic [NHARTS-1:0] halted;
        logic [NHARTS-1:0] ack;
        logic              busy;
        logic [2:0]        err;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // host-side updates first; hart events below override them
        if (host_go) begin
            st_d.go[sel] = 1'b1;
            st_d.busy    = 1'b1;
        end
        if (host_resume) begin
            st_d.res[sel] = 1'b1;
            st_d.ack[sel] = 1'b0;
        end
        if (host_err_clr) begin
            st_d.err = '0;
        end
        if (ev_halt) begin
            st_d.halted[ev_id] = 1'b1;
            if (ev_id == sel && !st_q.go[ev_id]) begin
                st_d.busy = 1'b0;
            end
        end
        if (ev_going) begin
            st_d.go[sel] = 1'b0;
        end
        if (ev_resume) begin
            st_d.halted[ev_id] = 1'b0;
            st_d.ack[ev_id]    = 1'b1;
            st_d.res[ev_id]    = 1'b0;
        end
        if (ev_exc && st_q.err == '0) begin
            st_d.err = ERR_EXC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign go_o     = st_q.go;
    assign res_o    = st_q.res;
    assign halted_o = st_q.halted;
    assign ack_o    = st_q.ack;
    assign busy_o   = st_q.busy;
    assign err_o    = st_q.err;

    assert_halt_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_halt |=> halted_o[$past(ev_id)]);

    assert_halt_unbusy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_halt && ev_id == sel && !go_o[ev_id]) |=> !busy_o);

    assert_going_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_going |=> !go_o[$past(sel)]);

    assert_resume_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_resume |=> (ack_o[$past(ev_id)] && !halted_o[$past(ev_id)] && !res_o[$past(ev_id)]));

    assert_exc_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_exc && err_o == '0) |=> (err_o == ERR_EXC));

    assert_err_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o != '0 && !host_err_clr) |=> $stable(err_o));

endmodule

// File: rtl/dbgmem_store.sv
module dbgmem_store #(
    parameter int DATA_WORDS = 2,
    parameter int PB_WORDS   = 4,
    localparam int DIW       = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1,
    localparam int PIW       = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        hart_we,
    input  logic [DIW-1:0]              hart_idx,
    input  logic [31:0]                 hart_wdata,
    input  logic                        host_data_we,
    input  logic [DIW-1:0]              host_data_idx,
    input  logic [31:0]                 host_data_wdata,
    input  logic                        host_pb_we,
    input  logic [PIW-1:0]              host_pb_idx,
    input  logic [31:0]                 host_pb_wdata,
    output logic [DATA_WORDS-1:0][31:0] data_o,
    output logic [PB_WORDS-1:0][31:0]   pb_o
);
    typedef struct packed {
        logic [DATA_WORDS-1:0][31:0] data;
        logic [PB_WORDS-1:0][31:0]   pb;
    } store_st_t;

    store_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (host_pb_we) begin
            st_d.pb[host_pb_idx] = host_pb_wdata;
        end
        if (host_data_we) begin
            st_d.data[host_data_idx] = host_data_wdata;
        end
        // hart write applied last so it wins on a shared index
        if (hart_we) begin
            st_d.data[hart_idx] = hart_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o = st_q.data;
    assign pb_o   = st_q.pb;

    assert_hart_data_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hart_we |=> (data_o[$past(hart_idx)] == $past(hart_wdata)));

endmodule

// File: rtl/dbgmem_window.sv
module dbgmem_window
    import dbgmem_pkg::*;
#(
    parameter int          NHARTS     = 4,
    parameter int          DATA_WORDS = 2,
    parameter int          PB_WORDS   = 4,
    parameter int          ROM_WORDS  = 8,
    parameter int          AW         = 10,
    parameter logic [31:0] ROM_SEED   = 32'hD0B0_0000,
    parameter int          JUMP_WADDR = 64,
    parameter int          ABS_WADDR  = 192,
    parameter int          DATA_WADDR = 208,
    parameter int          FLAG_WADDR = 256,
    parameter int          ROM_WADDR  = 512,
    localparam int         HW         = (NHARTS > 1) ? $clog2(NHARTS) : 1,
    localparam int         DIW        = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1,
    localparam int         PIW        = (PB_WORDS > 1) ? $clog2(PB_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [HW-1:0]     req_hart,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err,
    input  logic [HW-1:0]     host_sel,
    input  logic              host_go,
    input  logic              host_resume,
    input  logic              host_err_clr,
    input  logic              host_data_we,
    input  logic [DIW-1:0]    host_data_idx,
    input  logic [31:0]       host_data_wdata,
    output logic [31:0]       host_data_rdata,
    input  logic              host_pb_we,
    input  logic [PIW-1:0]    host_pb_idx,
    input  logic [31:0]       host_pb_wdata,
    input  logic [31:0]       abs_insn0,
    input  logic [31:0]       abs_insn1,
    output logic              busy,
    output logic [2:0]        err_code,
    output logic [NHARTS-1:0] halted,
    output logic [NHARTS-1:0] resume_ack
);
    localparam int          FLAG_WORDS = (NHARTS + 3) / 4;
    localparam logic [31:0] JUMP_WORD  = jal_x0((ABS_WADDR - JUMP_WADDR) * 4);

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [31:0] rdata;
    } rsp_st_t;

    rsp_st_t rsp_d, rsp_q;

    region_e       region;
    logic [AW-1:0] offset;
    logic          legal;
    logic          acc_ok;
    logic          wr_ok;
    logic [NHARTS-1:0]           go_v, res_v;
    logic [DATA_WORDS-1:0][31:0] data_v;
    logic [PB_WORDS-1:0][31:0]   pb_v;
    int                          h;

    dbgmem_decode #(
        .AW(AW), .JUMP_WADDR(JUMP_WADDR), .ABS_WADDR(ABS_WADDR), .PB_WORDS(PB_WORDS),
        .DATA_WADDR(DATA_WADDR), .DATA_WORDS(DATA_WORDS), .FLAG_WADDR(FLAG_WADDR),
        .FLAG_WORDS(FLAG_WORDS), .ROM_WADDR(ROM_WADDR), .ROM_WORDS(ROM_WORDS)
    ) u_decode (
        .addr   (req_addr),
        .write  (req_write),
        .region (region),
        .offset (offset),
        .legal  (legal)
    );

    assign acc_ok = req_valid && legal;
    assign wr_ok  = acc_ok && req_write;

    dbgmem_flags #(.NHARTS(NHARTS)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev_halt      (wr_ok && region == RG_MB_HALT),
        .ev_going     (wr_ok && region == RG_MB_GOING),
        .ev_resume    (wr_ok && region == RG_MB_RESUME),
        .ev_exc       (wr_ok && region == RG_MB_EXC),
        .ev_id        (req_hart),
        .sel          (host_sel),
        .host_go      (host_go),
        .host_resume  (host_resume),
        .host_err_clr (host_err_clr),
        .go_o         (go_v),
        .res_o        (res_v),
        .halted_o     (halted),
        .ack_o        (resume_ack),
        .busy_o       (busy),
        .err_o        (err_code)
    );

    dbgmem_store #(.DATA_WORDS(DATA_WORDS), .PB_WORDS(PB_WORDS)) u_store (
        .clk             (clk),
        .rst_n           (rst_n),
        .hart_we         (wr_ok && region == RG_DATA),
        .hart_idx        (offset[DIW-1:0]),
        .hart_wdata      (req_wdata),
        .host_data_we    (host_data_we),
        .host_data_idx   (host_data_idx),
        .host_data_wdata (host_data_wdata),
        .host_pb_we      (host_pb_we),
        .host_pb_idx     (host_pb_idx),
        .host_pb_wdata   (host_pb_wdata),
        .data_o          (data_v),
        .pb_o            (pb_v)
    );

    assign host_data_rdata = data_v[host_data_idx];

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        h           = 0;
        if (req_valid && !legal) begin
            rsp_d.err = 1'b1;
        end else if (acc_ok && !req_write) begin
            unique case (region)
                RG_JUMP:  rsp_d.rdata = JUMP_WORD;
                RG_ABS:   rsp_d.rdata = offset[0] ? abs_insn1 : abs_insn0;
                RG_PROG:  rsp_d.rdata = pb_v[offset[PIW-1:0]];
                RG_DATA:  rsp_d.rdata = data_v[offset[DIW-1:0]];
                RG_FLAGS: begin
                    for (int b = 0; b < 4; b++) begin
                        h = int'(offset) * 4 + b;
                        if (h < NHARTS) begin
                            rsp_d.rdata[8*b + FLAG_GO_B]  = go_v[h[HW-1:0]];
                            rsp_d.rdata[8*b + FLAG_RES_B] = res_v[h[HW-1:0]];
                        end
                    end
                end
                RG_ROM:   rsp_d.rdata = ROM_SEED | 32'(offset);
                default:  rsp_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    assert_jump_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && int'(req_addr) == JUMP_WADDR) |=>
        (rsp_valid && !rsp_err && rsp_rdata == JUMP_WORD));

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_err_zero_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == '0));

    assert_bad_keeps_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !legal && !host_go && !host_resume && !host_err_clr) |=>
        ($stable(halted) && $stable(resume_ack) && $stable(busy) && $stable(err_code)));

endmodule

// File: tb/dbgmem_window_bench.sv
module dbgmem_window_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  req_hart = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic [1:0]  host_sel = '0;
    logic        host_go = 1'b0;
    logic        host_resume = 1'b0;
    logic        host_err_clr = 1'b0;
    logic        host_data_we = 1'b0;
    logic        host_data_idx = 1'b0;
    logic [31:0] host_data_wdata = '0;
    logic [31:0] host_data_rdata;
    logic        host_pb_we = 1'b0;
    logic [1:0]  host_pb_idx = '0;
    logic [31:0] host_pb_wdata = '0;
    logic [31:0] abs_insn0 = 32'h0000_0013;
    logic [31:0] abs_insn1 = 32'h0010_0073;
    logic        busy;
    logic [2:0]  err_code;
    logic [3:0]  halted;
    logic [3:0]  resume_ack;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // behavioural reference state
    logic [3:0]  m_go = '0, m_res = '0, m_halted = '0, m_ack = '0;
    logic        m_busy = 1'b0;
    logic [2:0]  m_err = '0;
    logic [31:0] m_data [2];
    logic [31:0] m_pb [4];

    always #10 clk = ~clk;

    dbgmem_window u_dbgmem_window (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_hart(req_hart),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .host_sel(host_sel), .host_go(host_go), .host_resume(host_resume),
        .host_err_clr(host_err_clr), .host_data_we(host_data_we),
        .host_data_idx(host_data_idx), .host_data_wdata(host_data_wdata),
        .host_data_rdata(host_data_rdata), .host_pb_we(host_pb_we),
        .host_pb_idx(host_pb_idx), .host_pb_wdata(host_pb_wdata),
        .abs_insn0(abs_insn0), .abs_insn1(abs_insn1),
        .busy(busy), .err_code(err_code), .halted(halted), .resume_ack(resume_ack)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cycles);
                summary();
            end
        end
    end

    function automatic void model_read(input logic w, input int a,
                                       output logic [31:0] rd, output logic e);
        rd = '0;
        e  = 1'b0;
        if (w) begin
            e = !((a >= 65 && a <= 68) || (a >= 208 && a <= 209));
        end else if (a == 64) rd = 32'h2000_006F;
        else if (a == 192) rd = abs_insn0;
        else if (a == 193) rd = abs_insn1;
        else if (a >= 194 && a <= 197) rd = m_pb[a - 194];
        else if (a >= 208 && a <= 209) rd = m_data[a - 208];
        else if (a == 256) begin
            for (int k = 0; k < 4; k++) begin
                rd[8*k]     = m_go[k];
                rd[8*k + 1] = m_res[k];
            end
        end else if (a >= 512 && a <= 519) rd = 32'hD0B0_0000 + 32'(a - 512);
        else e = 1'b1;
    endfunction

    // one cycle: drive at negedge, advance the model, compare at the next negedge
    task automatic step(input logic v, input logic w, input int a, input logic [31:0] wd,
                        input logic [1:0] id, input string tag);
        logic [31:0] e_rd;
        logic        e_err;
        logic [3:0]  old_go;
        logic [2:0]  old_err;
        req_valid = v;
        req_write = w;
        req_addr  = 10'(a);
        req_wdata = wd;
        req_hart  = id;
        model_read(w, a, e_rd, e_err);
        if (!v) begin e_rd = '0; e_err = 1'b0; end
        if (!v || e_err || w) e_rd = '0;
        old_go  = m_go;
        old_err = m_err;
        if (host_go) begin m_go[host_sel] = 1'b1; m_busy = 1'b1; end
        if (host_resume) begin m_res[host_sel] = 1'b1; m_ack[host_sel] = 1'b0; end
        if (host_err_clr) m_err = '0;
        if (host_pb_we) m_pb[host_pb_idx] = host_pb_wdata;
        if (host_data_we) m_data[host_data_idx] = host_data_wdata;
        if (v && w && !e_err) begin
            if (a == 65) begin
                m_halted[id] = 1'b1;
                if (id == host_sel && !old_go[id]) m_busy = 1'b0;
            end else if (a == 66) m_go[host_sel] = 1'b0;
            else if (a == 67) begin
                m_halted[id] = 1'b0; m_ack[id] = 1'b1; m_res[id] = 1'b0;
            end else if (a == 68) begin
                if (old_err == '0) m_err = 3'd3;
            end else m_data[a - 208] = wd;
        end
        @(negedge clk);
        n_cmp++;
        if (rsp_valid !== v || rsp_err !== e_err || rsp_rdata !== e_rd ||
            busy !== m_busy || err_code !== m_err || halted !== m_halted ||
            resume_ack !== m_ack || host_data_rdata !== m_data[host_data_idx]) begin
            n_bad++;
            $display("FAIL %s addr=%0h: actual v=%b e=%b rd=%h busy=%b err=%0d hlt=%b ack=%b hd=%h expected v=%b e=%b rd=%h busy=%b err=%0d hlt=%b ack=%b hd=%h",
                tag, a, rsp_valid, rsp_err, rsp_rdata, busy, err_code, halted, resume_ack,
                host_data_rdata, v, e_err, e_rd, m_busy, m_err, m_halted, m_ack,
                m_data[host_data_idx]);
        end
        req_valid    = 1'b0;
        host_go      = 1'b0;
        host_resume  = 1'b0;
        host_err_clr = 1'b0;
        host_data_we = 1'b0;
        host_pb_we   = 1'b0;
    endtask

    task automatic rd(input int a, input logic [1:0] id, input string tag);
        step(1'b1, 1'b0, a, 32'h0, id, tag);
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic [1:0] id, input string tag);
        step(1'b1, 1'b1, a, d, id, tag);
    endtask

    initial begin
        for (int i = 0; i < 2; i++) m_data[i] = '0;
        for (int i = 0; i < 4; i++) m_pb[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 0, 32'h0, 2'd0, "R1 reset state");
        rd(256, 2'd0, "R1 flags clear after reset");

        rd(64, 2'd0, "R2 jump word");
        rd(512, 2'd0, "R11 rom word 0");
        rd(519, 2'd3, "R11 rom word 7");
        rd(520, 2'd0, "R12 past rom end");

        host_pb_we = 1'b1; host_pb_idx = 2'd2; host_pb_wdata = 32'h1234_5678;
        step(1'b0, 1'b0, 0, 32'h0, 2'd0, "R10 host pb write");
        rd(196, 2'd1, "R10 pb read");
        rd(192, 2'd1, "R10 abs word 0");
        rd(193, 2'd1, "R10 abs word 1");
        wr(196, 32'hDEAD_0000, 2'd1, "R12 write to pb refused");
        rd(196, 2'd1, "R12 pb unchanged");

        host_data_we = 1'b1; host_data_idx = 1'b0; host_data_wdata = 32'h0000_00A5;
        step(1'b0, 1'b0, 0, 32'h0, 2'd0, "R9 host data write");
        rd(208, 2'd0, "R9 hart reads data0");
        wr(209, 32'hCAFE_F00D, 2'd2, "R9 hart writes data1");
        host_data_idx = 1'b1;
        rd(209, 2'd2, "R9 data1 readback");
        host_data_we = 1'b1; host_data_wdata = 32'h1111_1111;
        wr(209, 32'h2222_2222, 2'd0, "R9 same-cycle write hart wins");

        host_sel = 2'd1; host_go = 1'b1;
        step(1'b0, 1'b0, 0, 32'h0, 2'd0, "R7 host go");
        rd(256, 2'd1, "R8 go flag of hart 1");
        wr(65, 32'h0, 2'd1, "R3 halted while go set keeps busy");
        wr(66, 32'h0, 2'd2, "R4 going clears selected go");
        rd(256, 2'd1, "R4 flag word after going");
        wr(65, 32'h0, 2'd1, "R3 halted clears busy");

        host_go = 1'b1;
        wr(66, 32'h0, 2'd1, "R7 go and going same cycle");
        rd(256, 2'd1, "R7 going won over host go");
        wr(65, 32'h0, 2'd0, "R3 unselected hart halt keeps busy");
        wr(65, 32'h0, 2'd1, "R3 selected halt clears busy");

        host_resume = 1'b1;
        step(1'b0, 1'b0, 0, 32'h0, 2'd0, "R7 host resume");
        rd(256, 2'd1, "R8 resume flag of hart 1");
        wr(67, 32'h0, 2'd1, "R5 resuming mailbox");
        rd(256, 2'd1, "R5 resume flag cleared");
        host_sel = 2'd3; host_resume = 1'b1;
        wr(67, 32'h0, 2'd3, "R7 resume and resuming same cycle");
        rd(256, 2'd3, "R7 resuming won over host resume");

        wr(68, 32'h0, 2'd0, "R6 exception sets error");
        wr(68, 32'h0, 2'd2, "R6 exception with error set");
        host_err_clr = 1'b1;
        wr(68, 32'h0, 2'd2, "R7 clear with nonzero error");
        host_err_clr = 1'b1;
        wr(68, 32'h0, 2'd2, "R7 exception wins over clear");

        rd(65, 2'd0, "R12 mailbox read refused");
        rd(0, 2'd0, "R12 unmapped address");
        wr(64, 32'hFFFF_FFFF, 2'd0, "R12 jump word write refused");
        wr(300, 32'h1, 2'd1, "R12 unmapped write");
        rd(64, 2'd0, "R2 jump word unchanged");
        summary();
    end

endmodule